// File: doc/BRIEF.md
# Edge-Latched Digital I/O Port

This block gives a processor two byte-wide input ports, two byte-wide output ports that can be read back, and one interrupt source driven by an external line. Software reaches everything through a small byte-addressed register bus. That bus carries a word address, 32-bit write data, four byte enables, a write strobe and a read strobe. Read data is combinational and valid while the read strobe is high.

The external interrupt line passes through a synchronizer before edge detection. An edge of the polarity chosen in the interrupt CSR sets a pending flag. If another such edge arrives before software acknowledges the first, a separate missed flag is set. Both flags are cleared by writing a one to them. The request output is the pending flag gated by the enable bit.

A control byte can also make the block take a snapshot of both input ports on a chosen edge of the same line. Software can then read a coherent sample that was taken at the moment of the event.

Top module: `dio_edge_port`

## Requirements
- R1: After reset, both output ports are 0, the control byte is 0, and the CSR reads 0 (enable 0, polarity 0, pending 0, missed 0). The request output is low.
- R2: Word 0x04 holds the output ports. Byte lane 0 drives `out_a` and byte lane 1 drives `out_b`, each written only when its byte enable is set. Reads return the stored values, lanes 2 and 3 read 0, and writes to lanes 2 and 3 have no effect.
- R3: Byte 3 of word 0x00 is the control byte. Only bit 5 (latch enable) and bit 6 (latch edge: 0 rising, 1 falling) are stored. Its other bits, and byte 2 of the word, read 0.
- R4: Word 0x34 reads the ASCII revision word 0x32313041, which is 'A','0','1','2' from byte 0 up. Writes to it have no effect.
- R5: In the CSR at word 0x38, bit 6 selects the interrupt edge (0 rising, 1 falling). That edge of `irq_in` sets pending (bit 17) at most three clock edges after `irq_in` changes. The opposite edge leaves pending unchanged.
- R6: Writing 1 to CSR bit 17 through byte lane 2 clears pending. Writing 0 there leaves it set.
- R7: A selected edge that arrives while pending is already set sets missed (bit 23). Missed stays set until a 1 is written to bit 23, and that write does not touch pending.
- R8: When a pending-clear write and a new selected edge fall in the same cycle, pending stays set and missed is not set.
- R9: CSR bit 12 is the enable. `irq_out` is high exactly when pending and the enable are both set.
- R10: With control bit 5 set, bytes 0 and 1 of word 0x00 return `in_a`/`in_b` as captured on the edge that control bit 6 selects. Later input changes and edges of the other polarity do not alter that capture. With bit 5 clear, the bytes return the live synchronized inputs.
- R11: Unmapped words read 0, and `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W (6) | Byte address; bits above 1 select the word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables, lane 0 = bits 7:0 |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| in_a | input | PORT_W (8) | Input port A, asynchronous |
| in_b | input | PORT_W (8) | Input port B, asynchronous |
| irq_in | input | 1 | External interrupt line, asynchronous |
| out_a | output | PORT_W (8) | Output port A |
| out_b | output | PORT_W (8) | Output port B |
| irq_out | output | 1 | Interrupt request |

## Verification
The hardest case to reach is R8. An acknowledge write must land in the exact cycle in which the synchronized edge pulse is present. That cycle is three flops down the synchronizer path, so a random bus access almost never hits it. The stimulus counts clocks from the negedge on which `irq_in` toggles and issues the clear write two negedges later, so the write strobe and the edge pulse share one rising edge. It then confirms that pending survives and missed stays clear. The remaining bus traffic, output lanes and CSR lane writes use seeded random values checked against bench models.

// File: rtl/dio_pkg.sv
package dio_pkg;

   // word indices (byte address >> 2)
   localparam int WORD_IN  = 0;
   localparam int WORD_OUT = 1;
   localparam int WORD_REV = 13;
   localparam int WORD_CSR = 14;

   // CSR bit positions
   localparam int CSR_POL_BIT  = 6;
   localparam int CSR_EN_BIT   = 12;
   localparam int CSR_PEND_BIT = 17;
   localparam int CSR_MISS_BIT = 23;

   // control byte bit positions (within the byte)
   localparam int CTL_LATCH_BIT = 5;
   localparam int CTL_EDGE_BIT  = 6;

   typedef struct packed {
      logic miss;
      logic pend;
      logic en;
      logic pol;
   } irq_state_t;

endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dio_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("dio_sync: W must be at least 1");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] stg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stg_q <= '0;
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dio_irq_csr.sv
module dio_irq_csr
   import dio_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        rise,
   input  logic        fall,
   input  logic        wr,
   input  logic [2:0]  be,
   input  logic [31:0] wdata,
   output irq_state_t  st,
   output logic        irq_req
);

   irq_state_t st_q;
   logic       edge_sel;
   logic       clr_pend;
   logic       clr_miss;

   assign edge_sel = st_q.pol ? fall : rise;
   assign clr_pend = wr && be[2] && wdata[CSR_PEND_BIT];
   assign clr_miss = wr && be[2] && wdata[CSR_MISS_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= '0;
      end else begin
         if (wr && be[0]) st_q.pol <= wdata[CSR_POL_BIT];
         if (wr && be[1]) st_q.en  <= wdata[CSR_EN_BIT];
         // a fresh edge outranks an acknowledge in the same cycle
         if (edge_sel)      st_q.pend <= 1'b1;
         else if (clr_pend) st_q.pend <= 1'b0;
         if (edge_sel && st_q.pend && !clr_pend) st_q.miss <= 1'b1;
         else if (clr_miss)                      st_q.miss <= 1'b0;
      end
   end

   assign st      = st_q;
   assign irq_req = st_q.pend && st_q.en;

   assert_pend_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
      edge_sel |=> st_q.pend);

   assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend && !edge_sel) |=> !st_q.pend);

   assert_miss_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q.miss) |-> $past(st_q.pend));

   assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q.miss && !clr_miss) |=> st_q.miss);

   assert_race_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_sel && clr_pend && !st_q.miss) |=> (st_q.pend && !st_q.miss));

endmodule

// File: rtl/dio_in_capture.sv
module dio_in_capture #(
   parameter int PORT_W   = 8,
   parameter bit LATCH_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              latch_on,
   input  logic              edge_fall,
   input  logic [PORT_W-1:0] live_a,
   input  logic [PORT_W-1:0] live_b,
   output logic [PORT_W-1:0] rd_a,
   output logic [PORT_W-1:0] rd_b
);

   generate
      if (LATCH_EN) begin : g_latch
         logic              cap;
         logic [PORT_W-1:0] snap_a;
         logic [PORT_W-1:0] snap_b;

         assign cap = latch_on && (edge_fall ? fall : rise);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               snap_a <= '0;
               snap_b <= '0;
            end else if (cap) begin
               snap_a <= live_a;
               snap_b <= live_b;
            end
         end

         assign rd_a = latch_on ? snap_a : live_a;
         assign rd_b = latch_on ? snap_b : live_b;

         assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !cap |=> ($stable(snap_a) && $stable(snap_b)));
      end else begin : g_live
         assign rd_a = live_a;
         assign rd_b = live_b;
      end
   endgenerate

endmodule

// File: rtl/dio_edge_port.sv
module dio_edge_port
   import dio_pkg::*;
#(
   parameter int          ADDR_W      = 6,
   parameter int          PORT_W      = 8,
   parameter int          SYNC_STAGES = 2,
   parameter bit          LATCH_EN    = 1'b1,
   parameter logic [15:0] REV_DIGITS  = 16'h3132
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic [3:0]        bus_be,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [31:0]       bus_rdata,
   input  logic [PORT_W-1:0] in_a,
   input  logic [PORT_W-1:0] in_b,
   input  logic              irq_in,
   output logic [PORT_W-1:0] out_a,
   output logic [PORT_W-1:0] out_b,
   output logic              irq_out
);

   localparam int WORD_W = ADDR_W - 2;
   localparam int SYNC_W = 2 * PORT_W + 1;
   localparam logic [WORD_W-1:0] W_IN  = WORD_W'(WORD_IN);
   localparam logic [WORD_W-1:0] W_OUT = WORD_W'(WORD_OUT);
   localparam logic [WORD_W-1:0] W_REV = WORD_W'(WORD_REV);
   localparam logic [WORD_W-1:0] W_CSR = WORD_W'(WORD_CSR);
   localparam logic [31:0] REV_WORD = {REV_DIGITS[7:0], REV_DIGITS[15:8], 8'h30, 8'h41};

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("dio_edge_port: ADDR_W must be at least 6");
      end
      if (PORT_W < 1 || PORT_W > 8) begin : g_bad_port
         $error("dio_edge_port: PORT_W must be 1..8");
      end
      if (REV_DIGITS[15:8] < 8'h20 || REV_DIGITS[15:8] > 8'h7E ||
          REV_DIGITS[7:0]  < 8'h20 || REV_DIGITS[7:0]  > 8'h7E) begin : g_bad_rev
         $error("dio_edge_port: REV_DIGITS must be printable ASCII");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              wr_in, wr_out, wr_csr;
   logic              ctl_latch, ctl_edge;
   logic [PORT_W-1:0] out_a_q, out_b_q;
   logic [PORT_W-1:0] live_a, live_b, rd_a, rd_b;
   logic              irq_s, irq_prev, rise, fall;
   irq_state_t        st;

   assign word   = bus_addr[ADDR_W-1:2];
   assign wr_in  = bus_wr && (word == W_IN);
   assign wr_out = bus_wr && (word == W_OUT);
   assign wr_csr = bus_wr && (word == W_CSR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_latch <= 1'b0;
         ctl_edge  <= 1'b0;
         out_a_q   <= '0;
         out_b_q   <= '0;
      end else begin
         if (wr_in && bus_be[3]) begin
            ctl_latch <= bus_wdata[24 + CTL_LATCH_BIT];
            ctl_edge  <= bus_wdata[24 + CTL_EDGE_BIT];
         end
         if (wr_out && bus_be[0]) out_a_q <= bus_wdata[PORT_W-1:0];
         if (wr_out && bus_be[1]) out_b_q <= bus_wdata[8 +: PORT_W];
      end
   end

   dio_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({irq_in, in_b, in_a}),
      .q     ({irq_s, live_b, live_a})
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq_prev <= 1'b0;
      else        irq_prev <= irq_s;
   end

   assign rise = irq_s && !irq_prev;
   assign fall = !irq_s && irq_prev;

   dio_irq_csr u_csr (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .fall    (fall),
      .wr      (wr_csr),
      .be      (bus_be[2:0]),
      .wdata   (bus_wdata),
      .st      (st),
      .irq_req (irq_out)
   );

   dio_in_capture #(.PORT_W(PORT_W), .LATCH_EN(LATCH_EN)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (rise),
      .fall      (fall),
      .latch_on  (ctl_latch),
      .edge_fall (ctl_edge),
      .live_a    (live_a),
      .live_b    (live_b),
      .rd_a      (rd_a),
      .rd_b      (rd_b)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         case (word)
            W_IN: begin
               bus_rdata[7:0]  = 8'(rd_a);
               bus_rdata[15:8] = 8'(rd_b);
               bus_rdata[24 + CTL_LATCH_BIT] = ctl_latch;
               bus_rdata[24 + CTL_EDGE_BIT]  = ctl_edge;
            end
            W_OUT: begin
               bus_rdata[7:0]  = 8'(out_a_q);
               bus_rdata[15:8] = 8'(out_b_q);
            end
            W_REV: bus_rdata = REV_WORD;
            W_CSR: begin
               bus_rdata[CSR_POL_BIT]  = st.pol;
               bus_rdata[CSR_EN_BIT]   = st.en;
               bus_rdata[CSR_PEND_BIT] = st.pend;
               bus_rdata[CSR_MISS_BIT] = st.miss;
            end
            default: bus_rdata = '0;
         endcase
      end
   end

   assign out_a = out_a_q;
   assign out_b = out_b_q;

   assert_out_lane_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_out && bus_be[0]) |=> (out_a == $past(bus_wdata[PORT_W-1:0])));

   assert_out_hold_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_out && bus_be[1]) |=> $stable(out_b));

   assert_req_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (st.pend && st.en));

endmodule

// File: tb/dio_edge_port_bench.sv
module dio_edge_port_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [3:0]  bus_be = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic [7:0]  in_a = '0;
   logic [7:0]  in_b = '0;
   logic        irq_in = 1'b0;
   logic [7:0]  out_a, out_b;
   logic        irq_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   dio_edge_port u_dio_edge_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_be    (bus_be),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_rdata (bus_rdata),
      .in_a      (in_a),
      .in_b      (in_b),
      .irq_in    (irq_in),
      .out_a     (out_a),
      .out_b     (out_b),
      .irq_out   (irq_out)
   );

   function automatic logic [31:0] csr_word(bit miss, bit pend, bit en, bit pol);
      logic [31:0] w = '0;
      w[23] = miss; w[17] = pend; w[12] = en; w[6] = pol;
      return w;
   endfunction

   function automatic logic [31:0] in_word(logic [7:0] ctl, logic [7:0] a, logic [7:0] b);
      return {ctl & 8'h60, 8'h00, b, a};
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [5:0] a, logic [31:0] d, logic [3:0] be);
      bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic bus_read(logic [5:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic set_irq(logic v);
      irq_in = v;
      tick(4);
   endtask

   task automatic clear_flags();
      bus_write(6'h38, 32'h0082_0000, 4'b0100);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=timeout expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rv;
      logic [7:0]  ea, eb;
      bit          m_en, m_pol;
      void'($urandom(32'd4242));

      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      bus_read(6'h00, rv); chk("R1 word0", rv, 32'h0);
      bus_read(6'h04, rv); chk("R1 outputs readback", rv, 32'h0);
      bus_read(6'h38, rv); chk("R1 csr", rv, 32'h0);
      chk("R1 ports", {15'h0, irq_out, out_b, out_a}, 32'h0);

      // R4 revision word
      bus_read(6'h34, rv); chk("R4 revision", rv, 32'h3231_3041);
      bus_write(6'h34, 32'hFFFF_FFFF, 4'b1111);
      bus_read(6'h34, rv); chk("R4 revision after write", rv, 32'h3231_3041);

      // R3 control byte keeps only bits 6:5
      bus_write(6'h00, 32'hFFFF_FFFF, 4'b1111);
      bus_read(6'h00, rv); chk("R3 control mask", rv, 32'h6000_0000);
      bus_write(6'h00, 32'h0000_0000, 4'b1000);
      bus_read(6'h00, rv); chk("R3 control cleared", rv, 32'h0);

      // R2 output ports, directed
      bus_write(6'h04, 32'hFFFF_BBAA, 4'b1111);
      bus_read(6'h04, rv); chk("R2 both lanes", rv, 32'h0000_BBAA);
      bus_write(6'h04, 32'h0000_5511, 4'b0001);
      chk("R2 lane0 only ports", {16'h0, out_b, out_a}, 32'h0000_BB11);
      ea = 8'h11; eb = 8'hBB;
      // R2 random lane writes
      for (int i = 0; i < 40; i++) begin
         logic [31:0] d;
         logic [3:0]  be;
         d  = $urandom;
         be = 4'($urandom);
         bus_write(6'h04, d, be);
         if (be[0]) ea = d[7:0];
         if (be[1]) eb = d[15:8];
         chk("R2 random ports", {16'h0, out_b, out_a}, {16'h0, eb, ea});
         bus_read(6'h04, rv);
         chk("R2 random readback", rv, {16'h0, eb, ea});
      end

      // R11 unmapped word and idle read data
      bus_read(6'h08, rv); chk("R11 unmapped", rv, 32'h0);
      bus_addr = 6'h04; #1; chk("R11 rd low", bus_rdata, 32'h0);

      // R5 rising edge sets pending, R9 request
      bus_write(6'h38, 32'h0000_1000, 4'b0011);
      set_irq(1'b1);
      bus_read(6'h38, rv); chk("R5 rising sets pending", rv, csr_word(0, 1, 1, 0));
      chk("R9 request high", {31'h0, irq_out}, 32'h1);

      // R6 write-one-to-clear
      bus_write(6'h38, 32'h0000_0000, 4'b0100);
      bus_read(6'h38, rv); chk("R6 zero keeps pending", rv, csr_word(0, 1, 1, 0));
      bus_write(6'h38, 32'h0002_0000, 4'b0100);
      bus_read(6'h38, rv); chk("R6 one clears pending", rv, csr_word(0, 0, 1, 0));
      chk("R9 request low", {31'h0, irq_out}, 32'h0);

      // R5 opposite edge ignored
      set_irq(1'b0);
      bus_read(6'h38, rv); chk("R5 falling ignored", rv, csr_word(0, 0, 1, 0));

      // R7 missed
      set_irq(1'b1);
      set_irq(1'b0);
      set_irq(1'b1);
      bus_read(6'h38, rv); chk("R7 missed set", rv, csr_word(1, 1, 1, 0));
      bus_write(6'h38, 32'h0080_0000, 4'b0100);
      bus_read(6'h38, rv); chk("R7 missed cleared alone", rv, csr_word(0, 1, 1, 0));
      clear_flags();

      // R9 gating with enable off, R5 falling polarity
      bus_write(6'h38, 32'h0000_0040, 4'b0011);
      set_irq(1'b0);
      bus_read(6'h38, rv); chk("R5 falling sets pending", rv, csr_word(0, 1, 0, 1));
      chk("R9 disabled request", {31'h0, irq_out}, 32'h0);
      bus_write(6'h38, 32'h0000_1040, 4'b0011);
      chk("R9 enabled request", {31'h0, irq_out}, 32'h1);
      clear_flags();

      // R8 clear and edge in the same cycle
      set_irq(1'b1);
      set_irq(1'b0);
      set_irq(1'b1);
      irq_in = 1'b0;
      tick(2);
      bus_write(6'h38, 32'h0002_0000, 4'b0100);
      tick(3);
      bus_read(6'h38, rv); chk("R8 edge wins over clear", rv, csr_word(0, 1, 1, 1));
      clear_flags();
      bus_read(6'h38, rv); chk("R6 flags cleared", rv, csr_word(0, 0, 1, 1));

      // R10 input latching
      bus_write(6'h00, 32'h2000_0000, 4'b1000);
      in_a = 8'h5A; in_b = 8'hC3; tick(4);
      set_irq(1'b1);
      in_a = 8'h11; in_b = 8'h22; tick(4);
      bus_read(6'h00, rv); chk("R10 rising snapshot", rv, in_word(8'h20, 8'h5A, 8'hC3));
      bus_write(6'h00, 32'h0000_0000, 4'b1000);
      bus_read(6'h00, rv); chk("R10 live inputs", rv, in_word(8'h00, 8'h11, 8'h22));
      bus_write(6'h00, 32'h6000_0000, 4'b1000);
      in_a = 8'h77; in_b = 8'h88; tick(4);
      set_irq(1'b0);
      in_a = 8'h99; in_b = 8'hAA; tick(4);
      bus_read(6'h00, rv); chk("R10 falling snapshot", rv, in_word(8'h60, 8'h77, 8'h88));
      set_irq(1'b1);
      bus_read(6'h00, rv); chk("R10 rising ignored in falling mode", rv, in_word(8'h60, 8'h77, 8'h88));
      bus_write(6'h00, 32'h0000_0000, 4'b1000);
      bus_read(6'h00, rv); chk("R10 live after latch off", rv, in_word(8'h00, 8'h99, 8'hAA));

      // R5/R9 random CSR lane writes with a quiet line
      clear_flags();
      m_en = 1'b1; m_pol = 1'b1;
      for (int i = 0; i < 16; i++) begin
         logic [31:0] d;
         logic [1:0]  be;
         d  = $urandom & 32'h0000_1040;
         be = 2'($urandom);
         bus_write(6'h38, d, {2'b00, be});
         if (be[0]) m_pol = d[6];
         if (be[1]) m_en = d[12];
         bus_read(6'h38, rv);
         chk("R5 random csr lanes", rv, csr_word(0, 0, m_en, m_pol));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule